// File: doc/BRIEF.md
# Three-Wire Serial Word-Memory Read Interface

This block is the device side of a small serial memory port. It has a select line, a serial clock, a serial data input, and a data output with a separate output-enable that stands in for a tri-state pin. Every input is sampled on the rising edge of the serial clock, and only while select is high.

The block waits for the first high data bit after select rises and treats it as the start marker. Any low bits clocked in before that marker are filler and are thrown away. After the marker, the block takes in a 2-bit command and then a 6-bit word address, each most significant bit first. For the read command it turns the output on, sends a single low filler bit, and then sends stored 16-bit words, most significant bit first. It moves on to the next address after each word, and wraps from the top address back to zero. It keeps doing this until select goes low.

The storage is a 64-entry array of 16-bit words, which a test environment fills through a side load port.

Top module: `ser_read_slave`

## Requirements
- R1: After reset, `dout_oe` is 0.
- R2: While select is high, rising edges with `din` low before the first high bit are ignored. The first rising edge with `din` high is the start marker, and decoding begins on the next edge.
- R3: The 8 bits after the start marker are a 2-bit command followed by a 6-bit address, each most significant bit first. The command value binary 10 (1 first, then 0) selects a read.
- R4: For a read, after the rising edge that samples the last address bit, `dout_oe` is 1 and `dout` is 0 (the filler bit).
- R5: Each later rising edge shifts out one data bit. Bit 15 of the addressed word comes first and bit 0 comes last.
- R6: After bit 0 of a word, the next edge delivers bit 15 of the word at the following address, with no new command.
- R7: Reading continues past address 63 to address 0.
- R8: For any command value other than binary 10, `dout_oe` stays 0 for all remaining edges until select goes low.
- R9: When select goes low, `dout_oe` drops at once and the operation in progress is dropped. The next select period starts over with a search for a start marker.
- R10: A rising edge with `ld_en` high writes `ld_data` into the word at `ld_addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Serial clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Select; high enables the serial interface |
| din | input | 1 | Serial data input |
| dout | output | 1 | Serial data output value |
| dout_oe | output | 1 | Output enable; 0 means high impedance |
| ld_en | input | 1 | Side-port word write enable |
| ld_addr | input | 6 | Side-port word address |
| ld_data | input | 16 | Side-port word value |

## Verification
The hardest state to reach is the address rollover in the middle of a continuous read. It needs a full command, a start address near the top, and more than forty uninterrupted clock edges with select held high. The bench reaches it with a read that starts at address 62 and runs through three words, so the stream crosses from 63 to 0. A second hard case is dropping select partway through a command or a word and then showing that the next select period starts cleanly. The bench does this by deasserting select in the middle and then reading a different address at once.

// File: rtl/ser_read_pkg.sv
`timescale 1ns/1ps
package ser_read_pkg;
   typedef enum logic [1:0] {
      DEC_HUNT = 2'd0,
      DEC_SHIFT = 2'd1,
      DEC_HOLD = 2'd2
   } dec_state_t;
endpackage

// File: rtl/ser_cmd_decoder.sv
`timescale 1ns/1ps
module ser_cmd_decoder
   import ser_read_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int OPC_W = 2,
   parameter logic [OPC_W-1:0] RD_OPC = 2'b10
) (
   input  logic              sclk,
   input  logic              rst_n,
   input  logic              cs,
   input  logic              din,
   output logic              rd_hit,
   output logic [ADDR_W-1:0] rd_addr
);
   localparam int CMD_W = OPC_W + ADDR_W;
   localparam int CNT_W = $clog2(CMD_W + 1);
   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(CMD_W - 1);

   generate
      if (OPC_W < 1 || ADDR_W < 1) begin : g_bad_width
         $error("ser_cmd_decoder: command field widths must be at least 1");
      end
   endgenerate

   dec_state_t       st_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CMD_W-1:0] sreg_q;
   logic [CMD_W-1:0] sreg_nx;
   logic             last_bit;

   assign sreg_nx  = {sreg_q[CMD_W-2:0], din};
   assign last_bit = (st_q == DEC_SHIFT) && (cnt_q == LAST_IDX);
   assign rd_hit   = cs && last_bit && (sreg_nx[CMD_W-1 -: OPC_W] == RD_OPC);
   assign rd_addr  = sreg_nx[ADDR_W-1:0];

   always_ff @(posedge sclk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= DEC_HUNT;
         cnt_q  <= '0;
         sreg_q <= '0;
      end else if (!cs) begin
         st_q  <= DEC_HUNT;
         cnt_q <= '0;
      end else begin
         unique case (st_q)
            DEC_HUNT: begin
               if (din) begin
                  st_q  <= DEC_SHIFT;
                  cnt_q <= '0;
               end
            end
            DEC_SHIFT: begin
               sreg_q <= sreg_nx;
               cnt_q  <= cnt_q + 1'b1;
               if (last_bit) st_q <= DEC_HOLD;
            end
            default: st_q <= DEC_HOLD;
         endcase
      end
   end

   // R3: a command produces at most one read launch per select period
   p_single_launch_r3: assert property (@(posedge sclk) disable iff (!rst_n)
      rd_hit |=> !rd_hit);
   // R3: the bit counter never runs beyond the command length
   p_cnt_bound_r3: assert property (@(posedge sclk) disable iff (!rst_n)
      (st_q == DEC_SHIFT) |-> (cnt_q <= LAST_IDX));
   // R2: decoding cannot begin on an edge that samples din low while hunting
   p_hunt_hold_r2: assert property (@(posedge sclk) disable iff (!rst_n)
      (cs && st_q == DEC_HUNT && !din) |=> (st_q == DEC_HUNT));
endmodule

// File: rtl/ser_word_store.sv
`timescale 1ns/1ps
module ser_word_store #(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 16
) (
   input  logic              sclk,
   input  logic              ld_en,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic [DATA_W-1:0] ld_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_word
);
   localparam int DEPTH = 1 << ADDR_W;

   generate
      if (ADDR_W > 10) begin : g_too_deep
         $error("ser_word_store: register array limited to 1024 words");
      end
   endgenerate

   logic [DEPTH-1:0][DATA_W-1:0] words;

   for (genvar g = 0; g < DEPTH; g++) begin : g_word
      logic [DATA_W-1:0] word_q;
      always_ff @(posedge sclk) begin
         if (ld_en && (ld_addr == ADDR_W'(g))) word_q <= ld_data;
      end
      assign words[g] = word_q;
   end

   assign rd_word = words[rd_addr];
endmodule

// File: rtl/ser_shift_out.sv
`timescale 1ns/1ps
module ser_shift_out #(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 16
) (
   input  logic              sclk,
   input  logic              rst_n,
   input  logic              cs,
   input  logic              rd_hit,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [DATA_W-1:0] cur_word,
   output logic [ADDR_W-1:0] cur_addr,
   output logic              oe_q,
   output logic              dout_q
);
   localparam int IDX_W = $clog2(DATA_W);
   localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(DATA_W - 1);

   generate
      if (DATA_W < 2) begin : g_bad_data
         $error("ser_shift_out: word width must be at least 2");
      end
   endgenerate

   logic [IDX_W-1:0]  idx_q;
   logic [ADDR_W-1:0] addr_q;

   assign cur_addr = addr_q;

   always_ff @(posedge sclk or negedge rst_n) begin
      if (!rst_n) begin
         oe_q   <= 1'b0;
         dout_q <= 1'b0;
         idx_q  <= TOP_IDX;
         addr_q <= '0;
      end else if (!cs) begin
         oe_q   <= 1'b0;
         dout_q <= 1'b0;
         idx_q  <= TOP_IDX;
      end else if (rd_hit) begin
         oe_q   <= 1'b1;
         dout_q <= 1'b0;
         idx_q  <= TOP_IDX;
         addr_q <= start_addr;
      end else if (oe_q) begin
         dout_q <= cur_word[idx_q];
         if (idx_q == '0) begin
            idx_q  <= TOP_IDX;
            addr_q <= addr_q + 1'b1;
         end else begin
            idx_q <= idx_q - 1'b1;
         end
      end
   end

   // R4: the first driven bit after launch is the low filler bit
   p_filler_low_r4: assert property (@(posedge sclk) disable iff (!rst_n)
      $rose(oe_q) |-> !dout_q);
   // R6, R7: after the last bit the address advances by one, modulo the depth
   p_addr_step_r7: assert property (@(posedge sclk) disable iff (!rst_n)
      (cs && oe_q && !rd_hit && idx_q == '0) |=> (addr_q == $past(addr_q) + 1'b1));
   // R9: one edge with select low leaves the output disabled
   p_deselect_hiz_r9: assert property (@(posedge sclk) disable iff (!rst_n)
      !$past(cs) |-> !oe_q);
   // R8: the output turns on only through a read launch
   p_launch_only_r8: assert property (@(posedge sclk) disable iff (!rst_n)
      $rose(oe_q) |-> $past(rd_hit));
endmodule

// File: rtl/ser_read_slave.sv
`timescale 1ns/1ps
module ser_read_slave #(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 16
) (
   input  logic              sclk,
   input  logic              rst_n,
   input  logic              cs,
   input  logic              din,
   output logic              dout,
   output logic              dout_oe,
   input  logic              ld_en,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic [DATA_W-1:0] ld_data
);
   localparam int OPC_W = 2;
   localparam logic [OPC_W-1:0] RD_OPC = 2'b10;

   logic              hit;
   logic [ADDR_W-1:0] hit_addr;
   logic [ADDR_W-1:0] walk_addr;
   logic [DATA_W-1:0] walk_word;
   logic              oe_r;
   logic              bit_r;

   ser_cmd_decoder #(.ADDR_W(ADDR_W), .OPC_W(OPC_W), .RD_OPC(RD_OPC)) u_dec (
      .sclk(sclk), .rst_n(rst_n), .cs(cs), .din(din),
      .rd_hit(hit), .rd_addr(hit_addr)
   );

   ser_word_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
      .sclk(sclk), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
      .rd_addr(walk_addr), .rd_word(walk_word)
   );

   ser_shift_out #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_out (
      .sclk(sclk), .rst_n(rst_n), .cs(cs), .rd_hit(hit),
      .start_addr(hit_addr), .cur_word(walk_word), .cur_addr(walk_addr),
      .oe_q(oe_r), .dout_q(bit_r)
   );

   assign dout_oe = oe_r & cs;
   assign dout    = bit_r & dout_oe;

   // R1: output disabled during reset
   always_comb begin
      if (!rst_n) p_reset_off_r1: assert (!dout_oe);
   end
endmodule

// File: tb/sim_ser_read_slave.sv
`timescale 1ns/1ps
module sim_ser_read_slave;
   logic        sclk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs = 1'b0;
   logic        din = 1'b0;
   logic        dout;
   logic        dout_oe;
   logic        ld_en = 1'b0;
   logic [5:0]  ld_addr = '0;
   logic [15:0] ld_data = '0;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 sclk = ~sclk;

   ser_read_slave u0 (
      .sclk(sclk), .rst_n(rst_n), .cs(cs), .din(din),
      .dout(dout), .dout_oe(dout_oe),
      .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data)
   );

   function automatic logic [15:0] ref_word(input int a);
      return 16'((a * 16'h0B3D) ^ 16'h5A96 ^ (a << 9));
   endfunction

   task automatic chk(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic clk_bit(input logic b);
      @(negedge sclk);
      din = b;
      @(posedge sclk);
      #1;
   endtask

   task automatic select_on();
      @(negedge sclk);
      cs = 1'b1;
   endtask

   task automatic select_off(input string req);
      @(negedge sclk);
      cs = 1'b0;
      #0.5;
      chk(req, dout_oe, 1'b0);
      clk_bit(1'b0);
      clk_bit(1'b0);
   endtask

   task automatic send_cmd(input logic [1:0] opc, input int addr);
      clk_bit(1'b1);
      clk_bit(opc[1]);
      clk_bit(opc[0]);
      for (int i = 5; i >= 0; i--) clk_bit(addr[i]);
   endtask

   task automatic read_words(input string req, input int addr, input int nw, input logic fill);
      chk("R4 oe", dout_oe, 1'b1);
      chk("R4 filler", dout, 1'b0);
      for (int w = 0; w < nw; w++) begin
         for (int b = 15; b >= 0; b--) begin
            clk_bit(fill);
            chk(req, dout, ref_word((addr + w) % 64)[b]);
            chk(req, dout_oe, 1'b1);
         end
      end
   endtask

   // R2, R5: filler zeros ahead of the start marker, single word
   task automatic t_dummy_lead();
      select_on();
      for (int i = 0; i < 7; i++) begin
         clk_bit(1'b0);
         chk("R2 idle", dout_oe, 1'b0);
      end
      send_cmd(2'b10, 13);
      read_words("R5 R10 data", 13, 1, 1'b0);
      select_off("R9");
   endtask

   // R6: stream across several words, din held high during data
   task automatic t_stream();
      select_on();
      send_cmd(2'b10, 30);
      read_words("R6 next word", 30, 3, 1'b1);
      select_off("R9");
   endtask

   // R7: rollover from the top address to zero
   task automatic t_wrap();
      select_on();
      clk_bit(1'b0);
      send_cmd(2'b10, 62);
      read_words("R7 wrap", 62, 3, 1'b0);
      select_off("R9");
   endtask

   // R8: other command codes leave the output off
   task automatic t_other_opc(input logic [1:0] opc);
      select_on();
      send_cmd(opc, 5);
      for (int i = 0; i < 24; i++) begin
         clk_bit(i[0]);
         chk("R8 off", dout_oe, 1'b0);
      end
      select_off("R9");
   endtask

   // R9, R3: abort inside a word and inside a command, then a fresh read
   task automatic t_abort();
      select_on();
      send_cmd(2'b10, 5);
      for (int i = 0; i < 7; i++) clk_bit(1'b0);
      chk("R9 live", dout_oe, 1'b1);
      select_off("R9 mid word");
      select_on();
      clk_bit(1'b1);
      clk_bit(1'b1);
      clk_bit(1'b0);
      clk_bit(1'b1);
      select_off("R9 mid cmd");
      select_on();
      send_cmd(2'b10, 9);
      read_words("R3 R9 fresh", 9, 1, 1'b0);
      select_off("R9");
   endtask

   initial begin
      repeat (3) @(posedge sclk);
      #1;
      chk("R1 reset", dout_oe, 1'b0);
      @(negedge sclk);
      rst_n = 1'b1;
      for (int a = 0; a < 64; a++) begin
         @(negedge sclk);
         ld_en = 1'b1;
         ld_addr = 6'(a);
         ld_data = ref_word(a);
      end
      @(negedge sclk);
      ld_en = 1'b0;
      chk("R1 idle", dout_oe, 1'b0);
      t_dummy_lead();
      t_stream();
      t_wrap();
      t_other_opc(2'b01);
      t_other_opc(2'b11);
      t_other_opc(2'b00);
      t_abort();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #200000;
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule